// File: doc/BRIEF.md
# Hardware handshake controller with hysteresis

This block automates the request-to-send / clear-to-send handshake of a serial port. The receive side watches the fill count of the receive FIFO. It drives an active-low RTS line that turns off when the count climbs to an upper threshold. The line turns on again only once the count has drained to a lower threshold. The gap between the two thresholds is chosen by a two-bit hysteresis select. Its position is set relative to the receive trigger level. The trigger level itself still drives the receive interrupt flag, independently of where RTS switches.

The transmit side synchronises the active-low CTS input from the far end. When CTS goes inactive, it withdraws a transmit-allowed signal. A character that is already being shifted out is allowed to finish: the signal drops only after the shifter reports the end of that character's stop bit. The signal returns when CTS is active again. A rising edge on the synchronised CTS line can raise a one-cycle interrupt pulse. The FIFO and the shift register are outside this block. Either automatic function can be switched off on its own.

Top module: `flow_ctl_hyst`

## Requirements
- R1: With automatic RTS disabled, `rts_n` equals the inverse of `sw_rts` one cycle after it is applied.
- R2: With `hyst_sel` = 00, trigger levels 8, 16, 24 and 28 turn RTS off (`rts_n`=1) at fill counts 16, 24, 28 and 28 respectively. They turn it on (`rts_n`=0) at 0, 8, 16 and 24. A trigger up to 8 uses the first pair, up to 16 the second, up to 24 the third, and anything above uses the last.
- R3: With `hyst_sel` = 01, RTS turns off when the count is at least trigger+4. It turns on when the count is at most trigger−4.
- R4: With `hyst_sel` = 10 or 11, RTS turns off when the count is at least trigger+6. It turns on when the count is at most trigger−6.
- R5: The upper threshold is clamped to `FIFO_DEPTH` and the lower threshold is clamped at 0. A full FIFO therefore always turns RTS off, and an empty one always turns it on.
- R6: While the count lies strictly between the two thresholds, `rts_n` keeps its previous value.
- R7: When automatic RTS is enabled, it starts in the on state (`rts_n`=0) unless the count is already at or above the upper threshold.
- R8: `rx_trig_irq` is 1 one cycle after `rx_level` ≥ `rx_trig`, and 0 otherwise. This is independent of the RTS thresholds.
- R9: With automatic CTS disabled, `tx_allow` stays 1 whatever `cts_n` does, and `cts_irq` stays 0.
- R10: With automatic CTS enabled and the transmitter idle, `cts_n`=1 clears `tx_allow` three cycles later. If `tx_busy` is 1 at that point, `tx_allow` stays 1 until `tx_char_done` pulses, then drops one cycle later.
- R11: When `cts_n` returns to 0, `tx_allow` returns to 1 three cycles later.
- R12: A 0→1 transition of `cts_n` produces a one-cycle `cts_irq` pulse three cycles later, only when both `auto_cts_en` and `cts_irq_en` are 1.
- R13: After reset, `rts_n`=1, `tx_allow`=1, `cts_irq`=0 and `rx_trig_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_rts_en | input | 1 | Enables automatic RTS from the fill count |
| auto_cts_en | input | 1 | Enables CTS gating of the transmitter |
| cts_irq_en | input | 1 | Enables the CTS rising-edge interrupt |
| sw_rts | input | 1 | Software RTS request, used when automatic RTS is off (1 = request) |
| rx_level | input | CNT_W | Receive FIFO fill count, 0..FIFO_DEPTH |
| rx_trig | input | CNT_W | Receive trigger level |
| hyst_sel | input | 2 | Hysteresis select: 00 stepped table, 01 ±4, 10/11 ±6 |
| cts_n | input | 1 | Clear-to-send from the far end, active low, asynchronous |
| tx_busy | input | 1 | Shifter has a character in flight |
| tx_char_done | input | 1 | One-cycle strobe at the end of a stop bit |
| rts_n | output | 1 | Request-to-send, active low |
| tx_allow | output | 1 | Shifter may start a new character |
| cts_irq | output | 1 | One-cycle pulse on a CTS deassertion |
| rx_trig_irq | output | 1 | Fill count has reached the trigger level |

## Verification
`rts_n` and `rx_trig_irq` are registered straight from their inputs, so they are due one cycle after a stimulus. `tx_allow` and `cts_irq` follow `cts_n` through a two-stage synchroniser and one output register, so they are due three cycles later. A `tx_char_done` strobe shows up on `tx_allow` one cycle later. The driver tags every expected value with the cycle number at which it is due. The monitor compares each one at the falling edge of exactly that cycle, and also compares the cycle after an interrupt pulse to show that the pulse has ended.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;

    typedef enum logic [1:0] {
        HYS_STEPPED  = 2'b00,
        HYS_NARROW   = 2'b01,
        HYS_WIDE     = 2'b10,
        HYS_WIDE_ALT = 2'b11
    } hyst_mode_e;

    // band half-widths for the symmetric modes
    localparam int NARROW_STEP = 4;
    localparam int WIDE_STEP   = 6;

    // stepped-mode trigger classes; each class switches at its neighbours
    localparam int STEP_L0 = 8;
    localparam int STEP_L1 = 16;
    localparam int STEP_L2 = 24;
    localparam int STEP_L3 = 28;

endpackage

// File: rtl/fc_thresholds.sv
module fc_thresholds
    import flowctl_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 128,
    parameter int unsigned CNT_W      = 8
) (
    input  logic [CNT_W-1:0] trig,
    input  logic [1:0]       hyst_sel,
    output logic [CNT_W-1:0] upper,
    output logic [CNT_W-1:0] lower
);

    localparam int DEPTH_I = int'(FIFO_DEPTH);

    int t_i;
    int up_i;
    int lo_i;

    always_comb begin
        t_i  = int'(trig);
        up_i = 0;
        lo_i = 0;
        case (hyst_mode_e'(hyst_sel))
            HYS_STEPPED: begin
                if (t_i <= STEP_L0) begin
                    up_i = STEP_L1;
                    lo_i = 0;
                end else if (t_i <= STEP_L1) begin
                    up_i = STEP_L2;
                    lo_i = STEP_L0;
                end else if (t_i <= STEP_L2) begin
                    up_i = STEP_L3;
                    lo_i = STEP_L1;
                end else begin
                    up_i = STEP_L3;
                    lo_i = STEP_L2;
                end
            end
            HYS_NARROW: begin
                up_i = t_i + NARROW_STEP;
                lo_i = t_i - NARROW_STEP;
            end
            default: begin
                up_i = t_i + WIDE_STEP;
                lo_i = t_i - WIDE_STEP;
            end
        endcase
        // keep both limits inside the physical FIFO range
        if (up_i > DEPTH_I) up_i = DEPTH_I;
        if (lo_i < 0)       lo_i = 0;
        if (lo_i > DEPTH_I) lo_i = DEPTH_I;
    end

    assign upper = CNT_W'(up_i);
    assign lower = CNT_W'(lo_i);

endmodule

// File: rtl/fc_rts.sv
module fc_rts #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             sw_rts,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] trig,
    input  logic [CNT_W-1:0] upper,
    input  logic [CNT_W-1:0] lower,
    output logic             rts_n,
    output logic             rx_irq
);

    typedef struct packed {
        logic off;     // hysteresis state: 1 = far end told to stop
        logic rts_n;
        logic rx_irq;
    } rts_st_t;

    localparam rts_st_t RTS_RESET = '{off: 1'b0, rts_n: 1'b1, rx_irq: 1'b0};

    rts_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!auto_en) begin
            // automatic mode always restarts from the on state
            st_d.off   = 1'b0;
            st_d.rts_n = ~sw_rts;
        end else begin
            if (level >= upper)      st_d.off = 1'b1;
            else if (level <= lower) st_d.off = 1'b0;
            st_d.rts_n = st_d.off;
        end
        st_d.rx_irq = (level >= trig);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RTS_RESET;
        else        st_q <= st_d;
    end

    assign rts_n  = st_q.rts_n;
    assign rx_irq = st_q.rx_irq;

endmodule

// File: rtl/fc_cts.sv
module fc_cts #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic irq_en,
    input  logic cts_n,
    input  logic tx_busy,
    input  logic tx_char_done,
    output logic tx_allow,
    output logic cts_irq
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   allow;
        logic                   irq;
    } cts_st_t;

    localparam cts_st_t CTS_RESET = '{sync: '0, prev: 1'b0, allow: 1'b1, irq: 1'b0};

    cts_st_t st_d, st_q;
    logic    cts_s;

    assign cts_s = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], cts_n};
        st_d.prev = cts_s;
        st_d.irq  = auto_en & irq_en & cts_s & ~st_q.prev;
        if (!auto_en || !cts_s) begin
            st_d.allow = 1'b1;
        end else if (tx_busy && !tx_char_done) begin
            // let the character in flight reach the end of its stop bit
            st_d.allow = st_q.allow;
        end else begin
            st_d.allow = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTS_RESET;
        else        st_q <= st_d;
    end

    assign tx_allow = st_q.allow;
    assign cts_irq  = st_q.irq;

endmodule

// File: rtl/flow_ctl_hyst.sv
module flow_ctl_hyst #(
    parameter int unsigned FIFO_DEPTH  = 128,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             cts_irq_en,
    input  logic             sw_rts,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic [1:0]       hyst_sel,
    input  logic             cts_n,
    input  logic             tx_busy,
    input  logic             tx_char_done,
    output logic             rts_n,
    output logic             tx_allow,
    output logic             cts_irq,
    output logic             rx_trig_irq
);

    logic [CNT_W-1:0] thr_hi;
    logic [CNT_W-1:0] thr_lo;

    fc_thresholds #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .CNT_W      (CNT_W)
    ) u_thr (
        .trig     (rx_trig),
        .hyst_sel (hyst_sel),
        .upper    (thr_hi),
        .lower    (thr_lo)
    );

    fc_rts #(
        .CNT_W (CNT_W)
    ) u_rts (
        .clk     (clk),
        .rst_n   (rst_n),
        .auto_en (auto_rts_en),
        .sw_rts  (sw_rts),
        .level   (rx_level),
        .trig    (rx_trig),
        .upper   (thr_hi),
        .lower   (thr_lo),
        .rts_n   (rts_n),
        .rx_irq  (rx_trig_irq)
    );

    fc_cts #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cts (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_en      (auto_cts_en),
        .irq_en       (cts_irq_en),
        .cts_n        (cts_n),
        .tx_busy      (tx_busy),
        .tx_char_done (tx_char_done),
        .tx_allow     (tx_allow),
        .cts_irq      (cts_irq)
    );

endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
    parameter int unsigned FIFO_DEPTH = 128,
    parameter int unsigned CNT_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             auto_rts_en,
    input logic             auto_cts_en,
    input logic             cts_irq_en,
    input logic             sw_rts,
    input logic [CNT_W-1:0] rx_level,
    input logic [CNT_W-1:0] rx_trig,
    input logic             tx_busy,
    input logic             tx_char_done,
    input logic             rts_n,
    input logic             tx_allow,
    input logic             cts_irq,
    input logic             rx_trig_irq
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        $rose(rst_n) |-> (rts_n && tx_allow && !cts_irq && !rx_trig_irq)); // R13

    AST_MANUAL_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |=> (rts_n == !$past(sw_rts))); // R1

    AST_FULL_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rx_level >= CNT_W'(FIFO_DEPTH)) |=> rts_n); // R5

    AST_EMPTY_FORCES_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rx_level == '0) |=> !rts_n); // R5

    AST_TRIG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rx_trig_irq == ($past(rx_level) >= $past(rx_trig)))); // R8

    AST_NO_GATE_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_cts_en |=> tx_allow); // R9

    AST_CHAR_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && tx_busy && !tx_char_done && tx_allow) |=> tx_allow); // R10

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cts_irq |=> !cts_irq); // R12

    AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        cts_irq |-> ($past(auto_cts_en) && $past(cts_irq_en))); // R12

endmodule

bind flow_ctl_hyst fc_checker #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .auto_rts_en  (auto_rts_en),
    .auto_cts_en  (auto_cts_en),
    .cts_irq_en   (cts_irq_en),
    .sw_rts       (sw_rts),
    .rx_level     (rx_level),
    .rx_trig      (rx_trig),
    .tx_busy      (tx_busy),
    .tx_char_done (tx_char_done),
    .rts_n        (rts_n),
    .tx_allow     (tx_allow),
    .cts_irq      (cts_irq),
    .rx_trig_irq  (rx_trig_irq)
);

// File: tb/tb_flow_ctl_hyst.sv
`timescale 1ns/1ps
module tb_flow_ctl_hyst;

    localparam int DEPTH = 128;
    localparam int CW    = 8;

    localparam int S_RTS = 0;
    localparam int S_TXA = 1;
    localparam int S_CIR = 2;
    localparam int S_RIR = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic auto_rts_en, auto_cts_en, cts_irq_en, sw_rts;
    logic [CW-1:0] rx_level, rx_trig;
    logic [1:0] hyst_sel;
    logic cts_n, tx_busy, tx_char_done;
    logic rts_n, tx_allow, cts_irq, rx_trig_irq;

    always #2.5 clk = ~clk;

    flow_ctl_hyst #(.FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .cts_irq_en(cts_irq_en), .sw_rts(sw_rts), .rx_level(rx_level), .rx_trig(rx_trig),
        .hyst_sel(hyst_sel), .cts_n(cts_n), .tx_busy(tx_busy), .tx_char_done(tx_char_done),
        .rts_n(rts_n), .tx_allow(tx_allow), .cts_irq(cts_irq), .rx_trig_irq(rx_trig_irq)
    );

    typedef struct {
        int    due;
        int    sig;
        logic  val;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    logic m_off = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic sig_val(int s);
        case (s)
            S_RTS:   return rts_n;
            S_TXA:   return tx_allow;
            S_CIR:   return cts_irq;
            default: return rx_trig_irq;
        endcase
    endfunction

    task automatic compare(int s, logic exp, string tag);
        logic act;
        act = sig_val(s);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d signal %0d actual=%b expected=%b", tag, cyc, s, act, exp);
        end
    endtask

    // monitor: pops every expectation whose cycle has come
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            for (int i = sbq.size() - 1; i >= 0; i--) begin
                if (sbq[i].due == cyc) begin
                    compare(sbq[i].sig, sbq[i].val, sbq[i].tag);
                    sbq.delete(i);
                end
            end
        end
    end

    task automatic expect_in(int lat, int s, logic v, string tag);
        exp_t e;
        e.due = cyc + lat;
        e.sig = s;
        e.val = v;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // thresholds taken from the requirements
    task automatic ref_thr(int trig, int hs, output int up, output int lo);
        if (hs == 0) begin
            if (trig <= 8)       begin up = 16; lo = 0;  end
            else if (trig <= 16) begin up = 24; lo = 8;  end
            else if (trig <= 24) begin up = 28; lo = 16; end
            else                 begin up = 28; lo = 24; end
        end else if (hs == 1) begin
            up = trig + 4; lo = trig - 4;
        end else begin
            up = trig + 6; lo = trig - 6;
        end
        if (up > DEPTH) up = DEPTH;
        if (lo < 0) lo = 0;
    endtask

    // driver: one cycle of receive-side stimulus with its expected results
    task automatic rx_step(int lvl, string tag);
        int up, lo;
        logic er;
        rx_level = CW'(lvl);
        if (!auto_rts_en) begin
            m_off = 1'b0;
            er = ~sw_rts;
        end else begin
            ref_thr(int'(rx_trig), int'(hyst_sel), up, lo);
            if (lvl >= up)      m_off = 1'b1;
            else if (lvl <= lo) m_off = 1'b0;
            er = m_off;
        end
        expect_in(1, S_RTS, er, tag);
        expect_in(1, S_RIR, (lvl >= int'(rx_trig)), "R8");
        tick(1);
    endtask

    task automatic cfg(int trig, int hs);
        rx_trig  = CW'(trig);
        hyst_sel = 2'(hs);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        auto_rts_en = 1'b0; auto_cts_en = 1'b0; cts_irq_en = 1'b0; sw_rts = 1'b0;
        rx_level = '0; rx_trig = 8'd16; hyst_sel = 2'b00;
        cts_n = 1'b0; tx_busy = 1'b0; tx_char_done = 1'b0;
        tick(3);
        rst_n = 1'b1;
        compare(S_RTS, 1'b1, "R13");
        compare(S_TXA, 1'b1, "R13");
        compare(S_CIR, 1'b0, "R13");
        compare(S_RIR, 1'b0, "R13");
        tick(1);

        // software-driven RTS
        sw_rts = 1'b1; rx_step(0, "R1");
        sw_rts = 1'b0; rx_step(0, "R1");

        // automatic mode starts on; stepped table, trigger 16
        auto_rts_en = 1'b1; cfg(16, 0);
        rx_step(0, "R7");
        rx_step(10, "R6");
        rx_step(15, "R8");
        rx_step(16, "R8");
        rx_step(23, "R2");
        rx_step(24, "R2");
        rx_step(20, "R6");
        rx_step(9, "R6");
        rx_step(8, "R2");
        rx_step(12, "R6");
        cfg(8, 0);
        rx_step(15, "R2"); rx_step(16, "R2"); rx_step(1, "R2"); rx_step(0, "R2");
        cfg(24, 0);
        rx_step(28, "R2"); rx_step(17, "R2"); rx_step(16, "R2");
        cfg(28, 0);
        rx_step(27, "R2"); rx_step(28, "R2"); rx_step(25, "R2"); rx_step(24, "R2");

        // symmetric bands
        cfg(32, 1);
        rx_step(35, "R3"); rx_step(36, "R3"); rx_step(29, "R3"); rx_step(28, "R3");
        cfg(32, 2);
        rx_step(37, "R4"); rx_step(38, "R4"); rx_step(27, "R4"); rx_step(26, "R4");
        cfg(32, 3);
        rx_step(37, "R4"); rx_step(38, "R4"); rx_step(27, "R4"); rx_step(26, "R4");

        // clamping at both ends
        cfg(126, 2);
        rx_step(127, "R5"); rx_step(128, "R5"); rx_step(121, "R5"); rx_step(120, "R5");
        cfg(4, 2);
        rx_step(1, "R6"); rx_step(10, "R5"); rx_step(1, "R5"); rx_step(0, "R5");
        rx_step(128, "R5");

        // leaving automatic mode while off hands RTS back to software
        auto_rts_en = 1'b0; sw_rts = 1'b1;
        rx_step(128, "R1");
        rx_level = '0;

        // CTS ignored when gating is off
        cts_n = 1'b1;
        expect_in(3, S_TXA, 1'b1, "R9");
        expect_in(3, S_CIR, 1'b0, "R9");
        tick(5);
        cts_n = 1'b0;
        tick(4);

        // idle transmitter: suspension and resume
        auto_cts_en = 1'b1; cts_irq_en = 1'b1;
        tick(1);
        cts_n = 1'b1;
        expect_in(2, S_TXA, 1'b1, "R10");
        expect_in(2, S_CIR, 1'b0, "R12");
        expect_in(3, S_TXA, 1'b0, "R10");
        expect_in(3, S_CIR, 1'b1, "R12");
        expect_in(4, S_CIR, 1'b0, "R12");
        tick(6);
        cts_n = 1'b0;
        expect_in(2, S_TXA, 1'b0, "R11");
        expect_in(3, S_TXA, 1'b1, "R11");
        tick(5);

        // busy transmitter: character finishes first
        tx_busy = 1'b1;
        cts_n = 1'b1;
        expect_in(3, S_TXA, 1'b1, "R10");
        expect_in(3, S_CIR, 1'b1, "R12");
        expect_in(6, S_TXA, 1'b1, "R10");
        tick(7);
        tx_char_done = 1'b1;
        expect_in(1, S_TXA, 1'b0, "R10");
        tick(1);
        tx_char_done = 1'b0; tx_busy = 1'b0;
        expect_in(3, S_TXA, 1'b0, "R10");
        tick(4);
        cts_n = 1'b0;
        expect_in(3, S_TXA, 1'b1, "R11");
        tick(5);

        // interrupt masked
        cts_irq_en = 1'b0;
        cts_n = 1'b1;
        expect_in(3, S_CIR, 1'b0, "R12");
        expect_in(3, S_TXA, 1'b0, "R10");
        expect_in(4, S_CIR, 1'b0, "R12");
        tick(6);
        cts_n = 1'b0;
        tick(5);

        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard left %0d expectations unchecked", sbq.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule